// File: doc/BRIEF.md
# Bus Memory Agent with Acknowledge

This block is a slave on a simple parallel memory bus that has a single master. It watches an address bus and two active-high strobes, read and write, and answers each valid access with an acknowledge. The acknowledge line is shared with other agents, so the block drives it only while it is answering and leaves it high-impedance at all other times. The data bus is bidirectional. The agent drives it only during a read it serves and listens to it during a write.

The address space is split into two regions. The lowest `ROM_WORDS` locations hold fixed, read-only contents. Each word is computed from its address and a seed parameter. Every location above that region is read/write storage. Every address and every strobe combination is decoded: each location maps to exactly one storage word, and an access takes place only under exactly one valid strobe. Both strobes high together is treated as no access. A write aimed at the read-only region is acknowledged so that the master can finish its cycle, but it has no effect on the contents.

Top module: `mem_bus_agent`

## Requirements
- R1: A read at an address from 0x00 to 0x1F returns the read-only word. With the default parameters that word is the address with its two nibbles swapped, XORed with 0xA5. For example, 0x00 gives 0xA5 and 0x1F gives 0x54.
- R2: A write at an address from 0x20 to 0xFF stores the data bus value. A later read of the same address returns that value.
- R3: A write at an address from 0x00 to 0x1F is acknowledged and leaves the read-only word unchanged.
- R4: The acknowledge is undriven while no strobe is present. It is driven to 1 from the first rising clock edge at which exactly one strobe is high.
- R5: The acknowledge stays driven while the strobe is held. It returns to high-impedance at the first rising clock edge after the strobe drops.
- R6: The agent drives the data bus only while the read strobe is high and the write strobe is low. Otherwise the data bus is high-impedance.
- R7: When both strobes are high together, there is no acknowledge, nothing is stored and the data bus is not driven.
- R8: An active-low asynchronous reset makes the acknowledge undriven at once, even while a strobe is held.
- R9: Decoding is complete. Addresses 0x1F and 0x20 fall on opposite sides of the region split, and 0x20, 0x21, 0x80 and 0xFF each hold their own word with no aliasing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W (8) | Address from the master |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| data | inout | DATA_W (8) | Bidirectional data bus |
| ack | inout | 1 | Shared acknowledge: driven 1 when answering, otherwise high-impedance |

## Verification
A wrong handshake state can be seen at the acknowledge pin within one clock. The pin may stay driven after the strobe has dropped, answer a cycle in which both strobes were high, or fail to rise at the first edge. Each of these is visible at the next sample. A wrong decode or a stray write to storage stays hidden until that location is read back. For this reason the stimulus reads back every written location, including the locations next to the region split and a read-only word after a write to it. An unwanted data-bus driver is found by reading the pulled-up bus when the agent should be silent, at an address whose stored word differs from the pull-up value.

// File: rtl/mba_pkg.sv
package mba_pkg;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'b00,
    CYC_READ  = 2'b01,
    CYC_WRITE = 2'b10,
    CYC_BAD   = 2'b11
  } cyc_e;

  function automatic cyc_e classify(input logic rd, input logic wr);
    return cyc_e'({wr, rd});
  endfunction

endpackage

// File: rtl/mba_decode.sv
module mba_decode
  import mba_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int ROM_WORDS = 32,
  localparam int RAM_WORDS = (1 << ADDR_W) - ROM_WORDS,
  localparam int RAM_IW    = $clog2(RAM_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  output logic              rd_ok,
  output logic              wr_ok,
  output logic              rom_hit,
  output logic              ram_we,
  output logic [RAM_IW-1:0] ram_idx
);

  cyc_e cyc;
  logic ram_hit;

  function automatic logic in_rom(input logic [ADDR_W-1:0] a);
    return a < ADDR_W'(ROM_WORDS);
  endfunction

  function automatic logic [RAM_IW-1:0] to_ram_index(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    off = a - ADDR_W'(ROM_WORDS);
    return off[RAM_IW-1:0];
  endfunction

  always_comb begin
    cyc     = classify(rd_stb, wr_stb);
    rom_hit = in_rom(addr);
    ram_hit = !rom_hit;
    rd_ok   = (cyc == CYC_READ);
    wr_ok   = (cyc == CYC_WRITE);
    ram_we  = wr_ok && ram_hit;
    ram_idx = to_ram_index(addr);
  end

endmodule

// File: rtl/mba_store.sv
module mba_store #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ROM_WORDS = 32,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5,
  localparam int RAM_WORDS = (1 << ADDR_W) - ROM_WORDS,
  localparam int RAM_IW    = $clog2(RAM_WORDS),
  localparam int HALF      = ADDR_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rom_hit,
  input  logic              ram_we,
  input  logic [RAM_IW-1:0] ram_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] ram [RAM_WORDS];

  function automatic logic [DATA_W-1:0] rom_word(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rot;
    rot = (a << HALF) | (a >> (ADDR_W - HALF));
    return DATA_W'(rot) ^ ROM_SEED;
  endfunction

  always_ff @(posedge clk) begin
    if (ram_we) ram[ram_idx] <= wdata;
  end

  always_comb begin
    if (rom_hit) rdata = rom_word(addr);
    else         rdata = ram[ram_idx];
  end

  AST_ROM_NEVER_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
    rom_hit |-> !ram_we); // R3

endmodule

// File: rtl/mba_ack.sv
module mba_ack (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic access,
  output logic ack_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ack_q <= 1'b0;
    else        ack_q <= access;
  end

  AST_ACK_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb ^ wr_stb) |=> ack_q); // R4

  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stb && !wr_stb) |=> !ack_q); // R5

  AST_NO_ACK_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_stb) |=> !ack_q); // R7

endmodule

// File: rtl/mem_bus_agent.sv
module mem_bus_agent #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int ROM_WORDS = 32,
  parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5,
  localparam int RAM_WORDS = (1 << ADDR_W) - ROM_WORDS,
  localparam int RAM_IW    = $clog2(RAM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_stb,
  input  logic              wr_stb,
  inout  wire  [DATA_W-1:0] data,
  inout  wire               ack
);

  logic              rd_ok, wr_ok, rom_hit, ram_we, ack_q;
  logic [RAM_IW-1:0] ram_idx;
  logic [DATA_W-1:0] rdata;
  logic              data_oe;

  mba_decode #(.ADDR_W(ADDR_W), .ROM_WORDS(ROM_WORDS)) u_dec (
    .addr(addr), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rd_ok(rd_ok), .wr_ok(wr_ok), .rom_hit(rom_hit),
    .ram_we(ram_we), .ram_idx(ram_idx)
  );

  mba_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROM_WORDS(ROM_WORDS),
              .ROM_SEED(ROM_SEED)) u_store (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rom_hit(rom_hit),
    .ram_we(ram_we), .ram_idx(ram_idx), .wdata(data), .rdata(rdata)
  );

  mba_ack u_ack (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .access(rd_ok | wr_ok), .ack_q(ack_q)
  );

  assign data_oe = rd_ok;
  assign data    = data_oe ? rdata : {DATA_W{1'bz}};
  assign ack     = ack_q ? 1'b1 : 1'bz;

  AST_BUS_DRIVEN_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (rd_stb && !wr_stb)); // R6

  AST_WRITE_HAS_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr_stb && !rd_stb)); // R7

endmodule

// File: tb/mem_bus_agent_test.sv
module mem_bus_agent_test;

  localparam int OP_W = 1;
  localparam int OP_R = 2;
  localparam int NV   = 12;
  // {op, addr, wdata, expected read}
  localparam logic [31:0] VEC [NV] = '{
    {8'd1, 8'h20, 8'h3C, 8'h00},
    {8'd1, 8'hFF, 8'hC3, 8'h00},
    {8'd1, 8'h21, 8'h00, 8'h00},
    {8'd2, 8'h20, 8'h00, 8'h3C},
    {8'd2, 8'hFF, 8'h00, 8'hC3},
    {8'd2, 8'h21, 8'h00, 8'h00},
    {8'd2, 8'h00, 8'h00, 8'hA5},
    {8'd2, 8'h1F, 8'h00, 8'h54},
    {8'd1, 8'h1F, 8'h00, 8'h00},
    {8'd2, 8'h1F, 8'h00, 8'h54},
    {8'd1, 8'h80, 8'h5A, 8'h00},
    {8'd2, 8'h80, 8'h00, 8'h5A}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic       tb_oe = 1'b0;
  logic [7:0] tb_dat = 8'h00;
  wire  [7:0] data;
  wire        ack;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  assign data = tb_oe ? tb_dat : 8'hzz;
  pulldown (ack);
  for (genvar i = 0; i < 8; i++) begin : g_pu
    pullup (data[i]);
  end

  mem_bus_agent uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .data(data), .ack(ack)
  );

  function automatic logic [7:0] ref_rom(input logic [7:0] a);
    return {a[3:0], a[7:4]} ^ 8'hA5;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cycle(input int op, input logic [7:0] a, input logic [7:0] wd,
                       input logic [7:0] exp, input string req);
    @(negedge clk);
    addr = a;
    rd_stb = (op == OP_R);
    wr_stb = (op == OP_W);
    tb_oe = (op == OP_W);
    tb_dat = wd;
    #1 check("R4 ack before edge", {7'd0, ack}, 8'd0);
    @(negedge clk);
    check("R4 ack after edge", {7'd0, ack}, 8'd1);
    if (op == OP_R) check(req, data, exp);
    rd_stb = 1'b0; wr_stb = 1'b0; tb_oe = 1'b0;
    #1 check("R6 bus released", data, 8'hFF);
    @(negedge clk);
    check("R5 ack released", {7'd0, ack}, 8'd0);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 ack idle in reset", {7'd0, ack}, 8'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 bus idle after reset", data, 8'hFF);

    // vector table: R1 R2 R3 R9
    for (int i = 0; i < NV; i++) begin
      cycle(int'(VEC[i][31:24]), VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
            "R1/R2/R3/R9 table read");
    end

    // R1 against the bench model over the whole read-only region
    for (int a = 0; a < 32; a++) cycle(OP_R, 8'(a), 8'h00, ref_rom(8'(a)), "R1 rom model");

    // R5: ack held for several cycles
    @(negedge clk);
    addr = 8'h20; rd_stb = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check("R5 ack held", {7'd0, ack}, 8'd1);
    end
    rd_stb = 1'b0;
    @(negedge clk);
    check("R5 ack dropped", {7'd0, ack}, 8'd0);

    // R6: no drive on read-only address without strobe
    addr = 8'h00;
    #1 check("R6 no strobe no drive", data, 8'hFF);

    // R7: both strobes
    cycle(OP_W, 8'h22, 8'h11, 8'h00, "R2 write");
    @(negedge clk);
    addr = 8'h22; rd_stb = 1'b1; wr_stb = 1'b1; tb_oe = 1'b1; tb_dat = 8'h77;
    @(negedge clk);
    check("R7 no ack double strobe", {7'd0, ack}, 8'd0);
    tb_oe = 1'b0;
    #1 check("R7 no drive double strobe", data, 8'hFF);
    rd_stb = 1'b0; wr_stb = 1'b0;
    cycle(OP_R, 8'h22, 8'h00, 8'h11, "R7 not stored");

    // R8: async reset while strobe held
    @(negedge clk);
    addr = 8'h40; rd_stb = 1'b1;
    @(negedge clk);
    check("R8 ack before reset", {7'd0, ack}, 8'd1);
    rst_n = 1'b0;
    #1 check("R8 ack cleared by reset", {7'd0, ack}, 8'd0);
    rd_stb = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule